// File: doc/BRIEF.md
# Gated-Clock Serial Bit Port

This block is the bit-level serial edge of an HDLC-style link controller. It runs on a fast system clock and watches two serial clock pins and one serial data pin. Through synchronizers it finds the programmed transition of the chosen serial clock. On each such transition it takes one data bit, builds bytes least significant bit first, and presents each finished byte on a valid/ready port that feeds a receive FIFO. A transmit half takes bytes from a valid/ready source and drives them, least significant bit first, on an output pin, one bit per rising transition of the transmit clock pin.

The serial clocks may stop and restart at any time (burst or gated clocks). After a receive reset the receiver takes its first bit on the first programmed transition. After a transmit reset the transmitter first waits for a falling transition of its clock and drives bit 0 on the rising transition after that, so it needs one extra transition to align. A receive clock pin can also serve as a second data input when the transmit clock pin clocks the receiver. Flag, bit-stuffing and CRC handling live in the next stage.

Receiver states: RX_ARMED (after reset or receive reset; goes to RX_RUN when enabled), RX_RUN (shifts bits; goes to RX_LOCKED when the enable drops, or to RX_STALL when the clock source or edge setting changes), RX_STALL (counts nothing; goes to RX_LOCKED when the enable drops), RX_LOCKED (ignores everything). A receive reset moves any state to RX_ARMED. Transmitter states: TX_WAIT_FALL (after reset; goes to TX_WAIT_RISE on a falling clock transition), TX_WAIT_RISE (drives bit 0 of the first byte on a rising transition, then goes to TX_RUN), TX_RUN (one bit per rising transition, fetching a byte every eight bits). A transmit reset moves any state to TX_WAIT_FALL.

Top module: `sbi_serial_port`

## Requirements
- R1: Received bits are packed least significant bit first: the first bit taken after a receive reset appears in rx_byte[0] and the eighth in rx_byte[7].
- R2: With rx_data_sel = 0 the data bit is taken from rx_dat_pin; with rx_data_sel = 1 it is taken from rx_clk_pin. The other data source has no effect.
- R3: With rx_clk_sel = 0 the receive clock is rx_clk_pin; with rx_clk_sel = 1 it is tx_clk_pin. Transitions on the clock pin not chosen have no effect.
- R4: With rx_edge_pol = 1 bits are taken on rising transitions of the receive clock; with rx_edge_pol = 0 on falling transitions.
- R5: While rx_enable is 0 no byte is delivered, whatever the serial pins do; a byte already presented stays on rx_byte with rx_valid high until taken.
- R6: Once rx_enable has been cleared, setting it again has no effect until rx_reset is pulsed; after that pulse the first bit is taken on the first programmed transition.
- R7: A change of rx_clk_sel or rx_edge_pol while the receiver is running stops bit counting, and no byte is delivered until rx_reset is pulsed.
- R8: rx_byte and rx_valid hold while rx_ready is 0; a byte that completes while the previous one is still held is dropped. If rx_ready is 1 in the cycle a byte completes, the held byte is taken and the new byte loaded in the same cycle.
- R9: After reset or a tx_reset pulse tx_dat is 1; rising transitions of tx_clk_pin before the first falling one are ignored, and bit 0 of the first byte appears after the first rising transition that follows a falling one.
- R10: Each following rising transition of tx_clk_pin drives the next bit, least significant bit first; tx_dat holds its value while the clock is stopped.
- R11: tx_ready is high for one cycle at each byte boundary; if tx_valid is low then, the eight bits of that slot are sent as 1 and tx_underrun is high for exactly one cycle.
- R12: A serial pin change takes effect at the outputs on the third system clock edge after it is first sampled (two synchronizer stages plus the edge register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_clk_pin | input | 1 | Dedicated receive clock, or second data input |
| tx_clk_pin | input | 1 | Transmit clock, optionally also the receive clock |
| rx_dat_pin | input | 1 | Main serial receive data |
| rx_enable | input | 1 | Receiver enable |
| rx_reset | input | 1 | Receive reset pulse |
| rx_data_sel | input | 1 | 0: rx_dat_pin, 1: rx_clk_pin as data |
| rx_clk_sel | input | 1 | 0: rx_clk_pin, 1: tx_clk_pin as receive clock |
| rx_edge_pol | input | 1 | 1: rising, 0: falling receive transition |
| tx_reset | input | 1 | Transmit reset pulse |
| rx_byte | output | BYTE_W | Received byte |
| rx_valid | output | 1 | rx_byte holds a byte |
| rx_ready | input | 1 | Consumer takes the byte |
| tx_byte | input | BYTE_W | Byte to transmit |
| tx_valid | input | 1 | tx_byte is available |
| tx_ready | output | 1 | Byte boundary: tx_byte taken if tx_valid |
| tx_dat | output | 1 | Serial transmit data |
| tx_underrun | output | 1 | One-cycle pulse: no byte at a boundary |

## Verification
Two functions can meet in one system clock: the completion of a received byte and the hand-off of the byte still held on the output port. The bench holds a byte with rx_ready low, feeds a second byte and raises rx_ready exactly in the cycle in which the last bit takes effect, so the old byte leaves and the new one is loaded at once; the result is judged by rx_byte showing the new value with rx_valid still high. The same cycle-accurate reference also covers a configuration change coinciding with serial traffic, where the stall must win over the bit count.

// File: rtl/sbi_pkg.sv
package sbi_pkg;

    typedef enum logic [1:0] {
        RX_LOCKED,
        RX_ARMED,
        RX_RUN,
        RX_STALL
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_WAIT_FALL,
        TX_WAIT_RISE,
        TX_RUN
    } tx_state_e;

    // positions of the serial pins inside the synchronized bundle
    localparam int PIN_RXD = 0;
    localparam int PIN_RXC = 1;
    localparam int PIN_TXC = 2;
    localparam int PIN_CNT = 3;

endpackage

// File: rtl/sbi_sync_edge.sv
module sbi_sync_edge #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    // STAGES synchronizer flops followed by one delay flop for edge detection
    logic [STAGES:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= pin_i;
            for (int s = 1; s <= STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign lvl_o = pipe[STAGES-1];

    for (genvar b = 0; b < WIDTH; b++) begin : g_edge
        assign rise_o[b] =  pipe[STAGES-1][b] & ~pipe[STAGES][b];
        assign fall_o[b] = ~pipe[STAGES-1][b] &  pipe[STAGES][b];
    end

endmodule

// File: rtl/sbi_rx_deser.sv
module sbi_rx_deser
    import sbi_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic                rst_cmd_i,
    input  logic                data_sel_i,
    input  logic                clk_sel_i,
    input  logic                pol_i,
    input  logic [PIN_CNT-1:0]  lvl_i,
    input  logic [PIN_CNT-1:0]  rise_i,
    input  logic [PIN_CNT-1:0]  fall_i,
    input  logic                ready_i,
    output logic [BYTE_W-1:0]   byte_o,
    output logic                valid_o
);

    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic [1:0]        cfg_q;
    logic [1:0]        cfg_now;
    logic              edge_hit;
    logic              bit_in;
    logic              cfg_moved;
    logic              shift_en;
    logic [BYTE_W-1:0] next_sh;

    assign cfg_now   = {clk_sel_i, pol_i};
    assign cfg_moved = (cfg_now != cfg_q);

    always_comb begin
        if (clk_sel_i) begin
            edge_hit = pol_i ? rise_i[PIN_TXC] : fall_i[PIN_TXC];
        end else begin
            edge_hit = pol_i ? rise_i[PIN_RXC] : fall_i[PIN_RXC];
        end
        bit_in = data_sel_i ? lvl_i[PIN_RXC] : lvl_i[PIN_RXD];
    end

    assign shift_en = (state_q == RX_RUN) && !rst_cmd_i && en_i && !cfg_moved && edge_hit;
    assign next_sh  = {bit_in, sh_q[BYTE_W-1:1]};

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (rst_cmd_i) begin
            state_d = RX_ARMED;
        end else begin
            unique case (state_q)
                RX_LOCKED: state_d = RX_LOCKED;
                RX_ARMED:  if (en_i) state_d = RX_RUN;
                RX_RUN: begin
                    if (!en_i)          state_d = RX_LOCKED;
                    else if (cfg_moved) state_d = RX_STALL;
                end
                RX_STALL:  if (!en_i) state_d = RX_LOCKED;
                default:   state_d = RX_LOCKED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sh_q    <= '0;
            cfg_q   <= '0;
            byte_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            if (rst_cmd_i || state_q == RX_ARMED) begin
                cnt_q <= '0;
                cfg_q <= cfg_now;
            end
            if (valid_o && ready_i) begin
                valid_o <= 1'b0;
            end
            if (shift_en) begin
                sh_q <= next_sh;
                if (cnt_q == LAST_BIT) begin
                    cnt_q <= '0;
                    if (!valid_o || ready_i) begin
                        byte_o  <= next_sh;
                        valid_o <= 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sbi_tx_ser.sv
module sbi_tx_ser
    import sbi_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_cmd_i,
    input  logic              clk_rise_i,
    input  logic              clk_fall_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              valid_i,
    output logic              ready_o,
    output logic              dat_o,
    output logic              underrun_o
);

    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    tx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic              boundary;

    assign boundary = clk_rise_i &&
                      (state_q == TX_WAIT_RISE || (state_q == TX_RUN && cnt_q == '0));
    assign ready_o  = boundary && !rst_cmd_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (rst_cmd_i) begin
            state_d = TX_WAIT_FALL;
        end else begin
            unique case (state_q)
                TX_WAIT_FALL: if (clk_fall_i) state_d = TX_WAIT_RISE;
                TX_WAIT_RISE: if (clk_rise_i) state_d = TX_RUN;
                TX_RUN:       state_d = TX_RUN;
                default:      state_d = TX_WAIT_FALL;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_WAIT_FALL;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            sh_q       <= '1;
            dat_o      <= 1'b1;
            underrun_o <= 1'b0;
        end else begin
            underrun_o <= 1'b0;
            if (rst_cmd_i) begin
                cnt_q <= '0;
                sh_q  <= '1;
                dat_o <= 1'b1;
            end else if (boundary) begin
                cnt_q <= CNT_W'(1);
                if (valid_i) begin
                    dat_o <= byte_i[0];
                    sh_q  <= {1'b1, byte_i[BYTE_W-1:1]};
                end else begin
                    dat_o      <= 1'b1;
                    sh_q       <= '1;
                    underrun_o <= 1'b1;
                end
            end else if (state_q == TX_RUN && clk_rise_i) begin
                dat_o <= sh_q[0];
                sh_q  <= {1'b1, sh_q[BYTE_W-1:1]};
                cnt_q <= (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sbi_serial_port.sv
module sbi_serial_port
    import sbi_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_clk_pin,
    input  logic              tx_clk_pin,
    input  logic              rx_dat_pin,
    input  logic              rx_enable,
    input  logic              rx_reset,
    input  logic              rx_data_sel,
    input  logic              rx_clk_sel,
    input  logic              rx_edge_pol,
    input  logic              tx_reset,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_dat,
    output logic              tx_underrun
);

    logic [PIN_CNT-1:0] pins;
    logic [PIN_CNT-1:0] lvl;
    logic [PIN_CNT-1:0] rise;
    logic [PIN_CNT-1:0] fall;

    always_comb begin
        pins          = '0;
        pins[PIN_RXD] = rx_dat_pin;
        pins[PIN_RXC] = rx_clk_pin;
        pins[PIN_TXC] = tx_clk_pin;
    end

    sbi_sync_edge #(
        .WIDTH (PIN_CNT),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pins),
        .lvl_o (lvl),
        .rise_o(rise),
        .fall_o(fall)
    );

    sbi_rx_deser #(
        .BYTE_W(BYTE_W)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (rx_enable),
        .rst_cmd_i (rx_reset),
        .data_sel_i(rx_data_sel),
        .clk_sel_i (rx_clk_sel),
        .pol_i     (rx_edge_pol),
        .lvl_i     (lvl),
        .rise_i    (rise),
        .fall_i    (fall),
        .ready_i   (rx_ready),
        .byte_o    (rx_byte),
        .valid_o   (rx_valid)
    );

    sbi_tx_ser #(
        .BYTE_W(BYTE_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_cmd_i (tx_reset),
        .clk_rise_i(rise[PIN_TXC]),
        .clk_fall_i(fall[PIN_TXC]),
        .byte_i    (tx_byte),
        .valid_i   (tx_valid),
        .ready_o   (tx_ready),
        .dat_o     (tx_dat),
        .underrun_o(tx_underrun)
    );

endmodule

// File: rtl/sbi_serial_port_chk.sv
module sbi_serial_port_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_enable,
    input logic              rx_ready,
    input logic              rx_valid,
    input logic [BYTE_W-1:0] rx_byte,
    input logic              tx_reset,
    input logic              tx_dat,
    input logic              tx_underrun
);

    // R5: nothing is delivered while the receiver is disabled
    a_r5_no_push_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !$rose(rx_valid));

    // R8: a presented byte holds until taken
    a_r8_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_byte)));

    // R9: transmit reset returns the line to idle
    a_r9_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reset |=> tx_dat);

    // R9: no underrun report right after a transmit reset
    a_r9_no_underrun_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reset |=> !tx_underrun);

    // R11: an underrun slot starts with an idle one
    a_r11_underrun_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |-> tx_dat);

    // R11: the underrun flag lasts a single cycle
    a_r11_underrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |=> !tx_underrun);

endmodule

bind sbi_serial_port sbi_serial_port_chk #(
    .BYTE_W(BYTE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_enable  (rx_enable),
    .rx_ready   (rx_ready),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .tx_reset   (tx_reset),
    .tx_dat     (tx_dat),
    .tx_underrun(tx_underrun)
);

// File: tb/tb_sbi_serial_port.sv
`timescale 1ns/1ps
module tb_sbi_serial_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       p_rxc = 1'b0, p_txc = 1'b0, p_rxd = 1'b0;
    logic       en = 1'b0, rrst = 1'b0, dsel = 1'b0, csel = 1'b0, pol = 1'b1;
    logic       trst = 1'b0;
    logic       rx_ready = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_valid = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_valid, tx_ready, tx_dat, tx_underrun;

    sbi_serial_port dut (
        .clk(clk), .rst_n(rst_n),
        .rx_clk_pin(p_rxc), .tx_clk_pin(p_txc), .rx_dat_pin(p_rxd),
        .rx_enable(en), .rx_reset(rrst), .rx_data_sel(dsel),
        .rx_clk_sel(csel), .rx_edge_pol(pol), .tx_reset(trst),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_dat(tx_dat), .tx_underrun(tx_underrun)
    );

    always #2.5 clk = ~clk;

    int    n_checks = 0;
    int    n_err = 0;
    string cur_req = "R12";

    // reference model state
    logic [2:0] hist[$];
    int         m_rx_st;            // 0 locked, 1 armed, 2 run, 3 stall
    int         m_cnt;
    logic [7:0] m_sh;
    logic [1:0] m_cap;
    logic       m_valid;
    logic [7:0] m_byte;
    int         m_tx_st;            // 0 wait fall, 1 wait rise, 2 run
    int         m_tcnt;
    logic [7:0] m_tsh;
    logic       m_tdat;
    logic       m_unf;
    logic [7:0] txq[$];
    int         n_taken_seen = 0;
    int         n_unf_seen = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_rx_st = 1; m_cnt = 0; m_sh = '0; m_cap = '0; m_valid = 0; m_byte = '0;
        m_tx_st = 0; m_tcnt = 0; m_tsh = '1; m_tdat = 1; m_unf = 0;
    endtask

    // one system clock: advance the model, compare every output
    task automatic tick();
        logic [2:0] nw, od;
        logic       hit, d, old_v, r2, f2, taken;
        logic [7:0] nb;
        @(negedge clk);
        hist.push_back({p_txc, p_rxc, p_rxd});
        taken = 0;
        if (!rst_n) begin
            model_reset();
        end else begin
            nw = hist[hist.size()-3];
            od = hist[hist.size()-4];
            if (csel) hit = pol ? (nw[2] & ~od[2]) : (~nw[2] & od[2]);
            else      hit = pol ? (nw[1] & ~od[1]) : (~nw[1] & od[1]);
            d = dsel ? nw[1] : nw[0];
            old_v = m_valid;
            if (old_v && rx_ready) m_valid = 0;
            if (rrst) begin
                m_rx_st = 1; m_cnt = 0; m_cap = {csel, pol};
            end else begin
                case (m_rx_st)
                    1: begin m_cap = {csel, pol}; m_cnt = 0; if (en) m_rx_st = 2; end
                    2: begin
                        if (!en) m_rx_st = 0;
                        else if ({csel, pol} != m_cap) m_rx_st = 3;
                        else if (hit) begin
                            nb = {d, m_sh[7:1]};
                            m_sh = nb;
                            if (m_cnt == 7) begin
                                m_cnt = 0;
                                if (!old_v || rx_ready) begin m_byte = nb; m_valid = 1; end
                            end else m_cnt++;
                        end
                    end
                    3: if (!en) m_rx_st = 0;
                    default: ;
                endcase
            end
            r2 = nw[2] & ~od[2];
            f2 = ~nw[2] & od[2];
            m_unf = 0;
            if (trst) begin
                m_tx_st = 0; m_tdat = 1; m_tcnt = 0; m_tsh = '1;
            end else if (r2 && (m_tx_st == 1 || (m_tx_st == 2 && m_tcnt == 0))) begin
                m_tx_st = 2; m_tcnt = 1;
                if (tx_valid) begin
                    m_tdat = tx_byte[0]; m_tsh = {1'b1, tx_byte[7:1]}; taken = 1;
                end else begin
                    m_tdat = 1; m_tsh = '1; m_unf = 1;
                end
            end else if (m_tx_st == 0 && f2) begin
                m_tx_st = 1;
            end else if (m_tx_st == 2 && r2) begin
                m_tdat = m_tsh[0]; m_tsh = {1'b1, m_tsh[7:1]};
                m_tcnt = (m_tcnt == 7) ? 0 : m_tcnt + 1;
            end
        end
        chk({cur_req, " rx_valid"}, 32'(rx_valid), 32'(m_valid));
        if (m_valid) chk({cur_req, " rx_byte"}, 32'(rx_byte), 32'(m_byte));
        chk({cur_req, " tx_dat"}, 32'(tx_dat), 32'(m_tdat));
        chk({cur_req, " tx_underrun"}, 32'(tx_underrun), 32'(m_unf));
        if (tx_underrun) n_unf_seen++;
        if (tx_ready && tx_valid) n_taken_seen++;
        if (taken) begin
            void'(txq.pop_front());
            tx_valid = (txq.size() > 0);
            tx_byte  = (txq.size() > 0) ? txq[0] : 8'h00;
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // drive one receive bit: data and inactive clock level, then wait
    task automatic rx_prep(input logic b);
        if (dsel) begin p_rxc = b; p_rxd = ~b; end
        else p_rxd = b;
        if (csel) p_txc = ~pol; else p_rxc = ~pol;
        if (!csel) p_txc = pol;
        else if (!dsel) p_rxc = pol;
        ticks(4);
    endtask

    task automatic rx_fire();
        if (csel) p_txc = pol; else p_rxc = pol;
        if (!csel) p_txc = ~pol;
        else if (!dsel) p_rxc = ~pol;
    endtask

    task automatic rx_bit(input logic b);
        rx_prep(b);
        rx_fire();
        ticks(4);
    endtask

    task automatic rx_send(input logic [7:0] v);
        for (int i = 0; i < 8; i++) rx_bit(v[i]);
    endtask

    task automatic take_byte();
        rx_ready = 1; tick(); rx_ready = 0; tick();
    endtask

    task automatic pulse_rrst();
        rrst = 1; tick(); rrst = 0; ticks(2);
    endtask

    task automatic tx_cycle(output logic b);
        p_txc = 0; ticks(4);
        p_txc = 1; ticks(4);
        b = tx_dat;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] got;
        logic       b;
        model_reset();
        for (int i = 0; i < 4; i++) hist.push_back(3'b000);
        ticks(3);
        chk("R5 reset rx_valid", 32'(rx_valid), 0);
        chk("R9 reset tx_dat", 32'(tx_dat), 1);
        rst_n = 1;
        ticks(2);

        // R1: rising-edge receive, LSB first
        cur_req = "R1";
        en = 1; ticks(2);
        rx_send(8'hA5);
        chk("R1 byte A5 valid", 32'(rx_valid), 1);
        chk("R1 byte A5 value", 32'(rx_byte), 32'h A5);

        // R5: disable keeps the held byte, then ignores the line
        cur_req = "R5";
        en = 0; ticks(3);
        chk("R5 held valid", 32'(rx_valid), 1);
        chk("R5 held value", 32'(rx_byte), 32'h A5);
        take_byte();
        chk("R5 taken", 32'(rx_valid), 0);
        rx_send(8'h77);
        chk("R5 no byte while disabled", 32'(rx_valid), 0);

        // R6: re-enable needs a receive reset
        cur_req = "R6";
        en = 1; ticks(2);
        rx_send(8'h77);
        chk("R6 no byte without reset", 32'(rx_valid), 0);
        pulse_rrst();
        rx_send(8'hC3);
        chk("R6 byte after reset", 32'(rx_byte), 32'h C3);
        chk("R6 valid after reset", 32'(rx_valid), 1);
        take_byte();

        // R12: output latency after the last active edge
        cur_req = "R12";
        for (int i = 0; i < 7; i++) rx_bit(1'(8'h81 >> i));
        rx_prep(1'b1);
        rx_fire();
        ticks(2);
        chk("R12 not yet valid", 32'(rx_valid), 0);
        tick();
        chk("R12 valid on third edge", 32'(rx_valid), 1);
        chk("R12 value", 32'(rx_byte), 32'h 81);
        ticks(2);
        take_byte();

        // R7: polarity change mid-byte stalls the receiver
        cur_req = "R7";
        rx_bit(1); rx_bit(1); rx_bit(1);
        pol = 0; ticks(2);
        rx_send(8'h00);
        rx_send(8'h00);
        chk("R7 stalled no byte", 32'(rx_valid), 0);

        // R4: falling-edge receive
        cur_req = "R4";
        pulse_rrst();
        rx_send(8'h3C);
        chk("R4 falling edge byte", 32'(rx_byte), 32'h 3C);
        take_byte();

        // R3: transmit clock pin drives the receiver
        cur_req = "R3";
        csel = 1; pol = 1; pulse_rrst();
        rx_send(8'h5A);
        chk("R3 alt clock byte", 32'(rx_byte), 32'h 5A);
        take_byte();

        // R2: receive clock pin used as data
        cur_req = "R2";
        dsel = 1; pulse_rrst();
        rx_send(8'h96);
        chk("R2 alt data byte", 32'(rx_byte), 32'h 96);
        take_byte();

        // R8: hold, drop, and same-cycle hand-off
        cur_req = "R8";
        dsel = 0; csel = 0; pulse_rrst();
        rx_send(8'h11);
        rx_send(8'h22);
        chk("R8 held byte kept", 32'(rx_byte), 32'h 11);
        take_byte();
        chk("R8 dropped byte", 32'(rx_valid), 0);
        rx_send(8'h44);
        for (int i = 0; i < 7; i++) rx_bit(1'(8'h88 >> i));
        rx_prep(1'b1);
        rx_fire();
        ticks(2);
        rx_ready = 1; tick(); rx_ready = 0;
        chk("R8 same-cycle valid", 32'(rx_valid), 1);
        chk("R8 same-cycle value", 32'(rx_byte), 32'h 88);
        ticks(2);
        take_byte();

        // R9: transmit alignment
        cur_req = "R9";
        en = 0;
        p_txc = 0; ticks(4);
        trst = 1; tick(); trst = 0; tick();
        n_unf_seen = 0; n_taken_seen = 0;
        txq.push_back(8'hB2); txq.push_back(8'h4D);
        tx_valid = 1; tx_byte = 8'hB2;
        p_txc = 1; ticks(4);
        chk("R9 rise before fall ignored", 32'(tx_dat), 1);
        tx_cycle(b);
        chk("R9 first bit after fall then rise", 32'(b), 0);
        got = {7'h0, b};

        // R10: remaining bits and a clock gap
        cur_req = "R10";
        for (int i = 1; i < 8; i++) begin tx_cycle(b); got[i] = b; end
        chk("R10 first byte", 32'(got), 32'h B2);
        for (int i = 0; i < 4; i++) begin tx_cycle(b); got[i] = b; end
        ticks(40);
        chk("R10 held across gap", 32'(tx_dat), 32'(got[3]));
        for (int i = 4; i < 8; i++) begin tx_cycle(b); got[i] = b; end
        chk("R10 second byte", 32'(got), 32'h 4D);

        // R11: underrun slot
        cur_req = "R11";
        for (int i = 0; i < 8; i++) begin tx_cycle(b); got[i] = b; end
        chk("R11 idle slot", 32'(got), 32'h FF);
        chk("R11 one underrun pulse", 32'(n_unf_seen), 1);
        chk("R11 bytes taken", 32'(n_taken_seen), 2);
        ticks(4);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule